// File: doc/BRIEF.md
# Retriggerable Resettable One-Shot Timer

This block is a clocked monostable pulse generator. It stands in for an RC one-shot and uses counters in place of an analog timing network. A qualified edge on either of two trigger inputs starts a pulse. `trigA` responds to a rising edge and needs `trigB` high. `trigB` responds to a falling edge and needs `trigA` low. While the pulse runs, `pulseOut` is high and `pulseOutN` is low. The pulse lasts `period` clock cycles, however long the trigger input stays asserted.

Every accepted trigger starts with a lockout phase of `discharge` cycles, during which further triggers are ignored. After the lockout the timer is in its charge phase. A trigger accepted in the charge phase restarts the full period, and the output stays high without a gap. When `noRetrig` is high, all triggers are ignored while the output is high, so every pulse is exactly one period long.

An active-low clear input ends any pulse at once. A power-on reset holds the block idle for a fixed number of cycles after `rstN` is released. Both resets assert asynchronously and are released synchronously. The two trigger inputs are asynchronous and pass through synchronizer flops before edge detection.

Top module: `pulse_oneshot`

## Requirements
- R1: A rising edge on `trigA` starts a pulse only if `trigB` is high when that edge is sampled. A rising edge on `trigA` while `trigB` is low has no effect.
- R2: A falling edge on `trigB` starts a pulse only if `trigA` is low when that edge is sampled. A falling edge on `trigB` while `trigA` is high has no effect.
- R3: An accepted trigger drives `pulseOut` high and `pulseOutN` low. The pulse width does not depend on how long the trigger input stays asserted.
- R4: While `clearN` is low, `pulseOut` is 0 and `pulseOutN` is 1, with no clock edge needed. A pulse in progress is abandoned and does not resume after `clearN` returns high.
- R5: While `rstN` is low, and for `POR_CYCLES` cycles after it is released, the outputs are `pulseOut`=0 and `pulseOutN`=1, and trigger edges are discarded.
- R6: Let the clock edge that accepts a trigger be edge t0. Triggers arriving at edges t1 through tD are ignored, where D is the sampled `discharge` value.
- R7: A trigger arriving at edge tk, with D < k ≤ P, is accepted. The output then stays high continuously for k+P cycles in total, where P is the sampled `period`.
- R8: The output returns low exactly P cycles after the last accepted trigger. A `period` or `discharge` value of 0 is treated as 1.
- R9: While `noRetrig` is high, trigger edges are ignored whenever `pulseOut` is high.
- R10: `period` and `discharge` are sampled at the edge that accepts a trigger. Later changes to them do not alter the pulse in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Power-on reset, active low, asynchronous assert |
| clearN | input | 1 | Functional clear, active low, asynchronous assert |
| trigA | input | 1 | Rising-edge trigger, qualified by `trigB` high |
| trigB | input | 1 | Falling-edge trigger, qualified by `trigA` low |
| noRetrig | input | 1 | 1 = ignore triggers while the output is high |
| period | input | CNT_W | Pulse length in clock cycles |
| discharge | input | DIS_W | Lockout length in clock cycles |
| pulseOut | output | 1 | Pulse output, high while timing |
| pulseOutN | output | 1 | Complement of `pulseOut` |

## Verification
The bench builds the block with `CNT_W`=8, `DIS_W`=4 and `POR_CYCLES`=4. The short power-on window lets the bench show that a trigger sent right after power-up is lost. The small counter widths keep periods of a few cycles, so each lockout boundary can be hit at the exact cycle: retrigger offsets of D and D+1, a retrigger on the last cycle of the period, and a lockout longer than the period. Zero-valued `period` and `discharge` inputs are also applied, to check that they are treated as 1.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;

  // Timer phase held by the control
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_DISCH  = 2'd1,
    PH_CHARGE = 2'd2
  } phase_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;  // capture period/discharge, restart counting
    logic step;  // advance the counters by one cycle
  } tmrStrobe_t;

endpackage

// File: rtl/oneshot_sync.sv
module oneshot_sync #(
  parameter int   STAGES  = 2,      // must be at least 2
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= {STAGES{RST_VAL}};
    else       chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/oneshot_dp.sv
module oneshot_dp
  import oneshot_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int DIS_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  tmrStrobe_t       strobe,
  input  logic [CNT_W-1:0] periodIn,
  input  logic [DIS_W-1:0] dischargeIn,
  output logic             remLast,
  output logic             lockLast,
  output logic             lockBusy
);

  localparam logic [CNT_W-1:0] ONE_P = CNT_W'(1);
  localparam logic [DIS_W-1:0] ONE_D = DIS_W'(1);

  logic [CNT_W-1:0] remCnt;
  logic [DIS_W-1:0] lockCnt;
  logic [CNT_W-1:0] loadP;
  logic [DIS_W-1:0] loadD;

  // Zero lengths are clamped to one cycle
  assign loadP = (periodIn == '0) ? ONE_P : periodIn;
  assign loadD = (dischargeIn == '0) ? ONE_D : dischargeIn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remCnt  <= '0;
      lockCnt <= '0;
    end else if (strobe.load) begin
      remCnt  <= loadP;
      lockCnt <= loadD;
    end else if (strobe.step) begin
      if (remCnt != '0)  remCnt  <= remCnt - ONE_P;
      if (lockCnt != '0) lockCnt <= lockCnt - ONE_D;
    end
  end

  assign remLast  = (remCnt == ONE_P);
  assign lockLast = (lockCnt == ONE_D);
  assign lockBusy = (lockCnt != '0);

  // With the control idle, no cycles may remain on the timer
  AST_IDLE_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.load && !strobe.step) |-> (remCnt == '0)); // R8

  // The control never advances an exhausted timer
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.step && !strobe.load) |-> (remCnt != '0)); // R8

endmodule

// File: rtl/oneshot_ctrl.sv
module oneshot_ctrl
  import oneshot_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int POR_CYCLES  = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       clearN,
  input  logic       trigA,
  input  logic       trigB,
  input  logic       noRetrig,
  input  logic       remLast,
  input  logic       lockLast,
  input  logic       lockBusy,
  output tmrStrobe_t strobe,
  output logic       coreRstN,
  output logic       pulseOn
);

  localparam int POR_W = $clog2(POR_CYCLES + 2);
  localparam logic [POR_W-1:0] POR_END = POR_W'(POR_CYCLES);
  localparam logic [POR_W-1:0] POR_INC = POR_W'(1);

  // Power-on hold: counts cycles after rstN release
  logic [POR_W-1:0] porCnt;
  logic             porDone;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         porCnt <= '0;
    else if (!porDone) porCnt <= porCnt + POR_INC;
  end
  assign porDone = (porCnt == POR_END);

  // Reset for the core: asserts at once, releases on the clock
  logic       rawRstN;
  logic [1:0] rstSync;

  assign rawRstN = rstN & clearN;

  always_ff @(posedge clk or negedge rawRstN) begin
    if (!rawRstN) rstSync <= 2'b00;
    else          rstSync <= {rstSync[0], porDone};
  end
  assign coreRstN = rstSync[1];

  // Trigger synchronizers, reset to the idle levels
  logic aSync, bSync;

  oneshot_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_syncA (
    .clk(clk), .rstN(coreRstN), .din(trigA), .dout(aSync));
  oneshot_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_syncB (
    .clk(clk), .rstN(coreRstN), .din(trigB), .dout(bSync));

  // Edge detection with cross qualification
  logic aPrev, bPrev, riseA, fallB, fireQ;

  assign riseA = aSync & ~aPrev & bSync;
  assign fallB = ~bSync & bPrev & ~aSync;

  always_ff @(posedge clk or negedge coreRstN) begin
    if (!coreRstN) begin
      aPrev <= 1'b0;
      bPrev <= 1'b1;
      fireQ <= 1'b0;
    end else begin
      aPrev <= aSync;
      bPrev <= bSync;
      fireQ <= riseA | fallB;   // coincident conditions merge into one
    end
  end

  // Phase machine
  phase_t phase, phaseNext;
  logic   accept;

  assign accept = fireQ & ((phase == PH_IDLE) |
                           ((phase == PH_CHARGE) & ~noRetrig));

  always_comb begin
    phaseNext = phase;
    if (accept) begin
      phaseNext = PH_DISCH;
    end else begin
      case (phase)
        PH_DISCH: begin
          if (remLast)       phaseNext = PH_IDLE;
          else if (lockLast) phaseNext = PH_CHARGE;
        end
        PH_CHARGE: if (remLast) phaseNext = PH_IDLE;
        default: phaseNext = phase;
      endcase
    end
  end

  always_ff @(posedge clk or negedge coreRstN) begin
    if (!coreRstN) phase <= PH_IDLE;
    else           phase <= phaseNext;
  end

  assign strobe.load = accept;
  assign strobe.step = (phase != PH_IDLE);
  assign pulseOn     = (phase != PH_IDLE);

  // The charge phase is only entered once the lockout count is spent
  AST_LOCK_SPENT: assert property (@(posedge clk) disable iff (!coreRstN)
    (phase == PH_CHARGE) |-> !lockBusy); // R6

  // An accepted trigger leaves the output high on the next cycle
  AST_LOAD_RAISES: assert property (@(posedge clk) disable iff (!coreRstN)
    strobe.load |=> pulseOn); // R3

  // Outside reset, the pulse only ends on the last counted cycle
  AST_PULSE_END: assert property (@(posedge clk) disable iff (!coreRstN)
    $fell(pulseOn) |-> $past(remLast)); // R8

endmodule

// File: rtl/pulse_oneshot.sv
module pulse_oneshot
  import oneshot_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int DIS_W       = 4,
  parameter int POR_CYCLES  = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clearN,
  input  logic             trigA,
  input  logic             trigB,
  input  logic             noRetrig,
  input  logic [CNT_W-1:0] period,
  input  logic [DIS_W-1:0] discharge,
  output logic             pulseOut,
  output logic             pulseOutN
);

  tmrStrobe_t strobe;
  logic       coreRstN;
  logic       remLast, lockLast, lockBusy;
  logic       pulseOn;

  oneshot_ctrl #(
    .SYNC_STAGES(SYNC_STAGES),
    .POR_CYCLES (POR_CYCLES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .clearN(clearN),
    .trigA(trigA), .trigB(trigB), .noRetrig(noRetrig),
    .remLast(remLast), .lockLast(lockLast), .lockBusy(lockBusy),
    .strobe(strobe), .coreRstN(coreRstN), .pulseOn(pulseOn));

  oneshot_dp #(
    .CNT_W(CNT_W),
    .DIS_W(DIS_W)
  ) u_dp (
    .clk(clk), .rstN(coreRstN), .strobe(strobe),
    .periodIn(period), .dischargeIn(discharge),
    .remLast(remLast), .lockLast(lockLast), .lockBusy(lockBusy));

  assign pulseOut  = pulseOn;
  assign pulseOutN = ~pulseOn;

  // A low clear holds the output low at every edge
  AST_CLEAR_FORCES: assert property (@(posedge clk) disable iff (!rstN)
    !clearN |-> !pulseOut); // R4

endmodule

// File: tb/sim_pulse_oneshot.sv
module sim_pulse_oneshot;

  localparam int CW   = 8;
  localparam int DW   = 4;
  localparam int PORC = 4;

  logic          clk = 1'b0;
  logic          rstN, clearN, trigA, trigB, noRetrig;
  logic [CW-1:0] period;
  logic [DW-1:0] discharge;
  logic          pulseOut, pulseOutN;

  always #10 clk = ~clk;   // 50 MHz

  pulse_oneshot #(.CNT_W(CW), .DIS_W(DW), .POR_CYCLES(PORC)) u0 (
    .clk(clk), .rstN(rstN), .clearN(clearN), .trigA(trigA), .trigB(trigB),
    .noRetrig(noRetrig), .period(period), .discharge(discharge),
    .pulseOut(pulseOut), .pulseOutN(pulseOutN));

  int nChecks = 0;
  int nFail   = 0;

  // Pulse monitor, sampled at the falling edge
  int   cyc = 0, riseCyc = 0, lastWidth = 0, pulseCnt = 0;
  logic qPrev = 1'b0;

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (pulseOut && !qPrev) riseCyc = cyc;
    if (!pulseOut && qPrev) begin
      lastWidth = cyc - riseCyc;
      pulseCnt  = pulseCnt + 1;
    end
    qPrev = pulseOut;
  end

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One-cycle trigger on the chosen input, from idle levels
  task automatic fire(input logic useB);
    if (!useB) begin
      trigA = 1'b1; @(negedge clk); trigA = 1'b0;
    end else begin
      trigB = 1'b0; @(negedge clk); trigB = 1'b1;
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  typedef struct packed {
    logic [7:0] per;
    logic [3:0] dis;
    logic       useB;
    logic [7:0] gap;   // 0 = single trigger, else offset of second trigger
    logic       noR;
    logic [7:0] expW;
    logic [3:0] req;
  } vec_t;

  localparam vec_t VECS [10] = '{
    '{per:8'd5,  dis:4'd2, useB:1'b0, gap:8'd0, noR:1'b0, expW:8'd5,  req:4'd3}, // R3 plain
    '{per:8'd1,  dis:4'd1, useB:1'b1, gap:8'd0, noR:1'b0, expW:8'd1,  req:4'd2}, // R2 B trigger
    '{per:8'd10, dis:4'd3, useB:1'b0, gap:8'd6, noR:1'b0, expW:8'd16, req:4'd7}, // R7 retrigger
    '{per:8'd10, dis:4'd3, useB:1'b0, gap:8'd3, noR:1'b0, expW:8'd10, req:4'd6}, // R6 k = D
    '{per:8'd10, dis:4'd3, useB:1'b1, gap:8'd4, noR:1'b0, expW:8'd14, req:4'd7}, // R7 k = D+1
    '{per:8'd8,  dis:4'd2, useB:1'b1, gap:8'd5, noR:1'b1, expW:8'd8,  req:4'd9}, // R9 blocked
    '{per:8'd6,  dis:4'd2, useB:1'b0, gap:8'd6, noR:1'b0, expW:8'd12, req:4'd7}, // R7 k = P
    '{per:8'd4,  dis:4'd6, useB:1'b0, gap:8'd3, noR:1'b0, expW:8'd4,  req:4'd6}, // R6 D > P
    '{per:8'd0,  dis:4'd0, useB:1'b0, gap:8'd0, noR:1'b0, expW:8'd1,  req:4'd8}, // R8 zero clamp
    '{per:8'd6,  dis:4'd2, useB:1'b0, gap:8'd2, noR:1'b0, expW:8'd6,  req:4'd6}  // R6 k = D
  };

  function automatic void summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
    $finish;
  end

  initial begin
    int base;
    rstN = 1'b0; clearN = 1'b1; trigA = 1'b0; trigB = 1'b1;
    noRetrig = 1'b0; period = 8'd5; discharge = 4'd2;

    // R5: outputs during power-on reset
    settle(3);
    check("R5 q in reset", int'(pulseOut), 0);
    check("R5 qn in reset", int'(pulseOutN), 1);

    // R5: trigger inside the power-on hold is lost
    rstN = 1'b1;
    fire(1'b0);
    settle(30);
    check("R5 pulses after hold", pulseCnt, 0);
    check("R5 q idle", int'(pulseOut), 0);

    // Vector table
    for (int i = 0; i < 10; i++) begin
      vec_t v;
      v = VECS[i];
      period = v.per; discharge = v.dis; noRetrig = v.noR;
      @(negedge clk);
      base = pulseCnt;
      fire(v.useB);
      if (v.gap != 8'd0) begin
        settle(int'(v.gap) - 1);
        fire(v.useB);
      end
      settle(40);
      check($sformatf("R%0d count v%0d", v.req, i), pulseCnt - base, 1);
      check($sformatf("R%0d width v%0d", v.req, i), lastWidth, int'(v.expW));
    end
    noRetrig = 1'b0;

    // R1 and R2: unqualified edges do nothing
    period = 8'd5; discharge = 4'd1;
    base = pulseCnt;
    trigA = 1'b1; trigB = 1'b0; settle(4);   // simultaneous: no trigger
    trigA = 1'b0; settle(4);
    trigA = 1'b1; settle(4);                 // A rises with B low
    check("R1 no pulse with B low", pulseCnt - base, 0);
    check("R1 q low", int'(pulseOut), 0);
    trigB = 1'b1; settle(4);
    trigB = 1'b0; settle(4);                 // B falls with A high
    check("R2 no pulse with A high", pulseCnt - base, 0);
    check("R2 q low", int'(pulseOut), 0);
    trigA = 1'b0; trigB = 1'b1; settle(8);
    check("R2 restore no pulse", pulseCnt - base, 0);

    // R3: long trigger still gives one period
    base = pulseCnt;
    trigA = 1'b1; settle(20); trigA = 1'b0; settle(10);
    check("R3 long trigger count", pulseCnt - base, 1);
    check("R3 long trigger width", lastWidth, 5);

    // R10: inputs changed mid-pulse do not alter width
    period = 8'd12; discharge = 4'd2;
    fire(1'b0);
    settle(3);
    period = 8'd3; discharge = 4'd1;
    settle(25);
    check("R10 width after change", lastWidth, 12);

    // R4: clear mid-pulse
    period = 8'd40; discharge = 4'd2;
    fire(1'b0);
    settle(10);
    check("R3 q high mid-pulse", int'(pulseOut), 1);
    check("R3 qn low mid-pulse", int'(pulseOutN), 0);
    clearN = 1'b0;
    #1;
    check("R4 q forced low", int'(pulseOut), 0);
    check("R4 qn forced high", int'(pulseOutN), 1);
    @(negedge clk); clearN = 1'b1;
    settle(60);
    check("R4 no resume", int'(pulseOut), 0);
    base = pulseCnt;
    period = 8'd5;
    fire(1'b1);
    settle(15);
    check("R4 new pulse count", pulseCnt - base, 1);
    check("R4 new pulse width", lastWidth, 5);

    summary();
    $finish;
  end

endmodule